// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge Wait

This block is the receive half of an I2C bus master. It takes over the bus once the slave address has been sent and the bus is already in the receive direction. It produces SCL from a programmable half-period, samples SDA on each rising SCL edge with the most significant bit first, and drives the acknowledge bit on the ninth clock. Reception is continuous: after a dummy read of the data port starts the first byte, each following byte is clocked in without further host action until a stop is requested.

The host sees a small register-style interface. It has a data read strobe and two control bits, one that enables waiting and one that gives the acknowledge level. It also has an interrupt flag that the host clears, a frame-complete flag, and a stop request strobe. With waiting enabled, the engine raises the interrupt flag when SCL falls after the eighth data bit. It then keeps SCL low until the host clears that flag, so software can choose the acknowledge level before the ninth clock. The frame-complete flag, together with a second setting of the interrupt flag, marks the rising edge of the ninth clock. At that point the received byte is moved into the data port.

For the last byte, the host clears the wait-enable bit and then the interrupt flag, and then requests a stop. After the ninth clock the engine pulls SDA low while SCL is low, raises SCL, and releases SDA while SCL is high. The bus is then left with both lines high.

Top module: `i2c_rx_wait`

## Requirements
- R1: After reset, scl_o is 0, sda_o is 1, irq_flag and frame_done are 0 and rx_data is 0. No SCL rising edge occurs until data_rd is pulsed.
- R2: A data_rd pulse while idle starts the first byte. Each SCL high phase and each SCL low phase lasts half_div system clocks, with values below 2 treated as 2.
- R3: Data bits are sampled on the rising SCL edge, first bit into rx_data bit 7. The master releases SDA (sda_o = 1) during every data-bit high phase.
- R4: With wait_en = 1, irq_flag is set when SCL falls after the 8th bit. SCL then stays low and frame_done stays 0 until irq_flag is cleared.
- R5: Clearing irq_flag by an irq_clr pulse releases the wait, and the 9th clock follows. Changing wait_en while waiting does not release SCL.
- R6: On the rising edge of the 9th clock, frame_done is set to 1 and irq_flag is set to 1. A data_rd pulse clears frame_done, and an irq_clr pulse clears irq_flag. A set on the same clock wins over a clear.
- R7: During the 9th clock, sda_o equals ack_val, where 0 is an acknowledge (SDA pulled low) and 1 is a not-acknowledge. The value is taken when the 9th clock's low phase begins.
- R8: With wait_en = 0, irq_flag is not set before the rising edge of the 9th clock, and SCL does not pause after the 8th bit.
- R9: After a frame, the next byte is clocked in without another data_rd. rx_data keeps the previous byte until the next frame completes.
- R10: After stop_req, once the current 9th clock ends, SDA goes low while SCL is low, SCL rises, and SDA then rises while SCL is high. SDA rising while SCL is high happens at no other time. Afterwards both lines stay high and data_rd starts no further clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | SCL half-period in system clocks (minimum 2) |
| wait_en | input | 1 | Wait-enable control bit |
| ack_val | input | 1 | Acknowledge level for the 9th clock (0 = ACK) |
| data_rd | input | 1 | Data port read strobe, one cycle |
| irq_clr | input | 1 | Interrupt flag clear strobe, one cycle |
| stop_req | input | 1 | Stop condition request strobe, one cycle |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL drive (0 = pull low, 1 = release) |
| sda_o | output | 1 | SDA drive (0 = pull low, 1 = release) |
| rx_data | output | DATA_W | Last completed received byte |
| irq_flag | output | 1 | Interrupt flag |
| frame_done | output | 1 | Frame-complete flag |

## Verification
A wrong bit counter or phase state shows at the ports within one SCL half-period. The flag edges then no longer line up with the right SCL edge: the interrupt flag would not follow the eighth falling edge, or the frame flag would rise in a low phase. A stuck wait state shows as SCL staying low after the flag is cleared, or pulsing while the flag is still set. A corrupted shift register or capture point shows as a wrong byte when the next frame completes. A bad SDA output decode shows as an early release of SDA that looks like a stop while SCL is high, caught on the very clock it happens.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DLO,
        ST_DHI,
        ST_HOLD,
        ST_ALO,
        ST_AHI,
        ST_PLO,
        ST_PHI,
        ST_DONE
    } rx_state_e;

endpackage

// File: rtl/i2cw_phase_timer.sv
// Counts system clocks inside one SCL half-period.
module i2cw_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] half_eff;

    always_comb begin
        half_eff = (half < MIN_HALF) ? MIN_HALF : half;
        tick     = (cnt_q >= half_eff - DIV_W'(1));
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2cw_shifter.sv
// Serial-in shift register, first bit ends up in the top position.
module i2cw_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) begin
            sh_d = {sh_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q;
endmodule

// File: rtl/i2c_rx_wait.sv
module i2c_rx_wait
    import i2cw_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              wait_en,
    input  logic              ack_val,
    input  logic              data_rd,
    input  logic              irq_clr,
    input  logic              stop_req,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq_flag,
    output logic              frame_done
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  bit_idx;
        logic              ack;
        logic              irq;
        logic              frame;
        logic              stop_pend;
        logic [DATA_W-1:0] data;
        logic              sda;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st:        ST_IDLE,
        bit_idx:   '0,
        ack:       1'b0,
        irq:       1'b0,
        frame:     1'b0,
        stop_pend: 1'b0,
        data:      '0,
        sda:       1'b1
    };

    ctrl_t cur_q, nxt_d;

    logic              tick;
    logic              timed;
    logic              advance;
    logic              restart;
    logic              shift_en;
    logic              set_irq;
    logic              set_frame;
    logic [DATA_W-1:0] shreg;

    i2cw_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .half    (half_div),
        .tick    (tick)
    );

    i2cw_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sda_i),
        .q        (shreg)
    );

    always_comb begin
        timed = (cur_q.st == ST_DLO) || (cur_q.st == ST_DHI) ||
                (cur_q.st == ST_ALO) || (cur_q.st == ST_AHI) ||
                (cur_q.st == ST_PLO) || (cur_q.st == ST_PHI);
        advance  = timed && tick;
        restart  = !timed || advance;
        shift_en = (cur_q.st == ST_DLO) && tick;
    end

    always_comb begin
        nxt_d     = cur_q;
        set_irq   = 1'b0;
        set_frame = 1'b0;
        nxt_d.stop_pend = cur_q.stop_pend | stop_req;

        unique case (cur_q.st)
            ST_IDLE: begin
                if (cur_q.stop_pend || stop_req) begin
                    nxt_d.st = ST_PLO;
                end else if (data_rd) begin
                    nxt_d.st      = ST_DLO;
                    nxt_d.bit_idx = '0;
                end
            end
            ST_DLO: begin
                if (advance) begin
                    nxt_d.st = ST_DHI;
                end
            end
            ST_DHI: begin
                if (advance) begin
                    if (cur_q.bit_idx == LAST_BIT) begin
                        if (wait_en) begin
                            nxt_d.st = ST_HOLD;
                            set_irq  = 1'b1;
                        end else begin
                            nxt_d.st  = ST_ALO;
                            nxt_d.ack = ack_val;
                        end
                    end else begin
                        nxt_d.st      = ST_DLO;
                        nxt_d.bit_idx = cur_q.bit_idx + CNT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (!cur_q.irq) begin
                    nxt_d.st  = ST_ALO;
                    nxt_d.ack = ack_val;
                end
            end
            ST_ALO: begin
                if (advance) begin
                    nxt_d.st   = ST_AHI;
                    nxt_d.data = shreg;
                    set_frame  = 1'b1;
                    set_irq    = 1'b1;
                end
            end
            ST_AHI: begin
                if (advance) begin
                    if (nxt_d.stop_pend) begin
                        nxt_d.st = ST_PLO;
                    end else begin
                        nxt_d.st      = ST_DLO;
                        nxt_d.bit_idx = '0;
                    end
                end
            end
            ST_PLO: begin
                if (advance) begin
                    nxt_d.st = ST_PHI;
                end
            end
            ST_PHI: begin
                if (advance) begin
                    nxt_d.st        = ST_DONE;
                    nxt_d.stop_pend = 1'b0;
                end
            end
            ST_DONE: begin
                nxt_d.stop_pend = 1'b0;
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase

        if (set_irq) begin
            nxt_d.irq = 1'b1;
        end else if (irq_clr) begin
            nxt_d.irq = 1'b0;
        end

        if (set_frame) begin
            nxt_d.frame = 1'b1;
        end else if (data_rd) begin
            nxt_d.frame = 1'b0;
        end

        // SDA follows the current phase one clock late, so it never
        // changes on the same edge as SCL.
        unique case (cur_q.st)
            ST_ALO, ST_AHI: nxt_d.sda = cur_q.ack;
            ST_PLO, ST_PHI: nxt_d.sda = 1'b0;
            default:        nxt_d.sda = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= CTRL_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_o      = (cur_q.st == ST_DHI) || (cur_q.st == ST_AHI) ||
                        (cur_q.st == ST_PHI) || (cur_q.st == ST_DONE);
    assign sda_o      = cur_q.sda;
    assign rx_data    = cur_q.data;
    assign irq_flag   = cur_q.irq;
    assign frame_done = cur_q.frame;
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk
    import i2cw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_o,
    input logic      sda_o,
    input logic      frame_done,
    input logic      irq_flag,
    input rx_state_e st
);
    // R4: SCL is held low during the wait
    assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !scl_o);

    // R5: the wait is left only after the flag is cleared
    assert_hold_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && irq_flag) |=> (st == ST_HOLD));

    // R6: frame completion lines up with SCL high
    assert_frame_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> scl_o);

    // R3: master releases SDA while data bits are high
    assert_release_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DHI) |-> sda_o);

    // R10: SDA rises with SCL high only as a stop
    assert_no_false_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_o) && scl_o && $past(scl_o)) |-> (st == ST_DONE));
endmodule

bind i2c_rx_wait i2cw_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .frame_done (frame_done),
    .irq_flag   (irq_flag),
    .st         (cur_q.st)
);

// File: tb/test_i2c_rx_wait.sv
`timescale 1ns/1ps
module test_i2c_rx_wait;
    localparam int HALF = 5;
    localparam int NV   = 4;
    localparam int NS   = 5;
    // vector: {byte, ack_val, wait_en}
    localparam logic [9:0] VEC [NV] = '{
        {8'hA5, 1'b0, 1'b1},
        {8'h3C, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1},
        {8'h5E, 1'b0, 1'b0}
    };
    localparam logic [7:0] SLV [NS] = '{8'hA5, 8'h3C, 8'h81, 8'h5E, 8'hC3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_div = 8'(HALF);
    logic       wait_en = 1'b0, ack_val = 1'b0;
    logic       data_rd = 1'b0, irq_clr = 1'b0, stop_req = 1'b0;
    logic       sda_i;
    logic       scl_o, sda_o, irq_flag, frame_done;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int sk = 0;
    int sb = 0;
    int scl_rises = 0;
    int hi_sda_rises = 0;
    logic prev_sda = 1'b1;
    logic prev_scl = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_rx_wait #(.DIV_W(8), .DATA_W(8)) i_i2c_rx_wait (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .wait_en(wait_en),
        .ack_val(ack_val), .data_rd(data_rd), .irq_clr(irq_clr),
        .stop_req(stop_req), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
        .rx_data(rx_data), .irq_flag(irq_flag), .frame_done(frame_done)
    );

    // Slave model: next bit placed after each SCL fall.
    always @(negedge scl_o) begin
        if (rst_n) begin
            if (sk == 8) begin
                sk = 0;
                sb = sb + 1;
            end else begin
                sk = sk + 1;
            end
        end
    end
    assign sda_i = (sk < 8 && sb < NS) ? SLV[sb][7-sk] : 1'b1;

    // Line monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_o && !prev_scl) scl_rises = scl_rises + 1;
            if (sda_o && !prev_sda && scl_o && prev_scl) hi_sda_rises = hi_sda_rises + 1;
        end
        prev_scl = scl_o;
        prev_sda = sda_o;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        case (which)
            0: data_rd = 1'b1;
            1: irq_clr = 1'b1;
            2: stop_req = 1'b1;
            default: begin data_rd = 1'b1; irq_clr = 1'b1; end
        endcase
        @(negedge clk);
        data_rd = 1'b0; irq_clr = 1'b0; stop_req = 1'b0;
    endtask

    // sel 0: irq_flag, 1: frame_done. early counts irq seen before frame.
    task automatic wait_flag(input int sel, output bit early);
        early = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            if (sel == 0 && irq_flag) return;
            if (sel == 1 && frame_done) return;
            if (sel == 1 && irq_flag) early = 1'b1;
            @(negedge clk);
        end
        check("timeout waiting for flag", 0, 1);
    endtask

    task automatic hold_check(input string req);
        int r0;
        r0 = scl_rises;
        repeat (20) @(negedge clk);
        check(req, {30'd0, scl_o, irq_flag}, 32'h1);
        check(req, scl_rises - r0, 0);
    endtask

    initial begin
        bit early;
        logic [7:0] prev_byte;
        int hi_cnt;
        int r0;
        prev_byte = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 scl", scl_o, 0);
        check("R1 sda", sda_o, 1);
        check("R1 flags", {irq_flag, frame_done}, 0);
        check("R1 rx_data", rx_data, 0);
        repeat (30) @(negedge clk);
        check("R1 no clocks before read", scl_rises, 0);

        wait_en = VEC[0][0];
        ack_val = VEC[0][1];
        pulse(0); // dummy read
        while (!scl_o) @(negedge clk);
        hi_cnt = 0;
        while (scl_o) begin hi_cnt++; @(negedge clk); end
        check("R2 high phase length", hi_cnt, HALF);
        hi_cnt = 0;
        while (!scl_o) begin hi_cnt++; @(negedge clk); end
        check("R2 low phase length", hi_cnt, HALF);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][0]) begin
                wait_flag(0, early);
                check("R4 irq at fall of clock 8", sk, 8);
                check("R4 scl low", scl_o, 0);
                check("R4 frame still 0", frame_done, 0);
                check("R9 rx_data kept", rx_data, prev_byte);
                hold_check("R4 held low");
                pulse(1);
            end
            wait_flag(1, early);
            if (!VEC[i][0]) check("R8 no early irq", early, 0);
            check("R3 byte", rx_data, VEC[i][9:2]);
            check("R6 scl high at frame", scl_o, 1);
            check("R6 ninth clock", sk, 8);
            check("R6 irq set", irq_flag, 1);
            check("R7 ack level", sda_o, VEC[i][1]);
            if (i + 1 < NV) begin
                wait_en = VEC[i+1][0];
                ack_val = VEC[i+1][1];
            end else begin
                wait_en = 1'b1;
                ack_val = 1'b1;
            end
            pulse(3);
            check("R6 flags cleared", {irq_flag, frame_done}, 0);
            prev_byte = VEC[i][9:2];
        end

        // Final byte: wait, drop wait_en, clear flag, stop.
        wait_flag(0, early);
        check("R9 rx_data kept before last", rx_data, prev_byte);
        wait_en = 1'b0;
        hold_check("R5 wait_en change does not release");
        pulse(1);
        pulse(2);
        wait_flag(1, early);
        check("R3 last byte", rx_data, 8'hC3);
        check("R7 nack level", sda_o, 1);
        check("R10 no stop yet", hi_sda_rises, 0);
        pulse(3);
        repeat (6 * HALF) @(negedge clk);
        check("R10 stop edge count", hi_sda_rises, 1);
        check("R10 bus released", {scl_o, sda_o}, 2'b11);
        r0 = scl_rises;
        pulse(0);
        repeat (40) @(negedge clk);
        check("R10 read after stop ignored", scl_rises - r0, 0);
        check("R10 lines stay high", {scl_o, sda_o}, 2'b11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule